// File: doc/BRIEF.md
# Trigger-Positioned Capture Buffer Controller

This block controls a wrap-around sample store for an on-chip logic-analyzer core. A one-cycle `arm` pulse starts a capture. From the next cycle on, every clock is one sample slot: the block decides whether the sample on `din` is worth a memory location, writes it into the ring with the number of sample slots counted since arming, and keeps overwriting the oldest entries until a trigger arrives. After the trigger it keeps exactly enough further entries to fill the memory, given the programmed pre-trigger share, and then freezes.

Two storage filters reduce memory use. Change-only storage skips samples that repeat the last stored value. Gated storage keeps a sample only while the `qual` input is high. Because of these filters, entries can be far apart in time, so each entry carries its timestamp. After capture, software-independent logic reads the result through `rd_addr`. Address 0 is always the oldest valid entry, and `valid_cnt` tells how many addresses hold data.

Top module: `capbuf_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `ts_ovf` are low and `valid_cnt` is 0.
- R2: An `arm` pulse clears the previous capture (`done`, `valid_cnt`, `ts_ovf`) and makes `busy` high from the next cycle. This applies also when a capture is still running.
- R3: With both filters off, every busy cycle stores the sample present on `din` in that cycle.
- R4: The first `trig` seen while busy and before any trigger is the trigger. Its sample is stored whatever the filters say, and `trig_addr` holds the physical memory slot of that entry. Physical slots are written 0,1,2,… after arming, modulo DEPTH. A `trig` that arrives after the trigger, or once capture is done, has no effect.
- R5: The trigger entry and the entries stored after it total DEPTH − `pre_cnt`, where `pre_cnt` ranges from 0 to DEPTH−1. When the last of them is written, `done` rises and `busy` falls in the next cycle, and nothing more is stored.
- R6: When at least `pre_cnt` samples were stored before the trigger, the trigger entry sits at readout address `pre_cnt`. With `pre_cnt` = 0 the whole memory is post-trigger. With `pre_cnt` = DEPTH−1 the trigger is the last entry.
- R7: A trigger that arrives before `pre_cnt` samples have been stored is accepted. `valid_cnt` then equals the number of samples stored before the trigger plus DEPTH − `pre_cnt`. `valid_cnt` never exceeds DEPTH.
- R8: Readout address i returns the i-th oldest valid entry. Once the ring has wrapped, address 0 is the slot after the newest entry.
- R9: With `mode_trans` high, a sample is stored only if it differs from the last stored sample. The first sample after arming is always stored.
- R10: With `mode_qual` high, a sample is stored only while `qual` is high. When both modes are on, both conditions must hold.
- R11: Each entry's `rd_ts` is the count of busy cycles before the one in which the sample was taken, modulo 2^TS_W. The first busy cycle has timestamp 0.
- R12: `ts_ovf` rises once the timestamp counter has wrapped during a capture. It stays high until the next `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Start (or restart) a capture |
| trig | input | 1 | Trigger event |
| din | input | DATA_W | Sample data |
| qual | input | 1 | Storage enable for gated mode |
| mode_trans | input | 1 | Change-only storage |
| mode_qual | input | 1 | Gated storage |
| pre_cnt | input | log2(DEPTH) | Pre-trigger entry count, held stable while busy |
| rd_addr | input | log2(DEPTH) | Readout address, 0 = oldest |
| busy | output | 1 | Capture running |
| done | output | 1 | Capture complete |
| trig_addr | output | log2(DEPTH) | Physical slot of the trigger entry |
| valid_cnt | output | log2(DEPTH)+1 | Number of valid entries |
| ts_ovf | output | 1 | Timestamp counter wrapped |
| rd_data | output | DATA_W | Sample at `rd_addr` |
| rd_ts | output | TS_W | Timestamp at `rd_addr` |

## Verification
The bench builds the block with DEPTH = 8, DATA_W = 8 and TS_W = 8. The small depth lets it sweep every pre-trigger count, for both early and late triggers, and read back every slot of every capture. The eight-bit timestamp wraps after 256 busy cycles, so a capture that never triggers reaches the overflow flag and timestamp wrap quickly. The other captures exercise change-only storage, gated storage and both together on repeating patterns, against a per-cycle model written from the requirements.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
   typedef enum logic [1:0] {
      CAP_IDLE = 2'd0,
      CAP_RUN  = 2'd1,
      CAP_POST = 2'd2,
      CAP_DONE = 2'd3
   } cap_state_e;
endpackage

// File: rtl/capbuf_filter.sv
module capbuf_filter #(
   parameter int DATA_W    = 8,
   parameter bit HAS_TRANS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              active,
   input  logic              force_store,
   input  logic [DATA_W-1:0] din,
   input  logic              qual,
   input  logic              mode_trans,
   input  logic              mode_qual,
   output logic              store
);
   logic qual_ok;
   logic trans_ok;

   assign qual_ok = !mode_qual || qual;
   assign store   = active && (force_store || (qual_ok && trans_ok));

   generate
      if (HAS_TRANS) begin : g_trans
         logic [DATA_W-1:0] last_q;
         logic              have_ref_q;
         assign trans_ok = !mode_trans || !have_ref_q || (din != last_q);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               last_q     <= '0;
               have_ref_q <= 1'b0;
            end else if (arm) begin
               have_ref_q <= 1'b0;
            end else if (store) begin
               last_q     <= din;
               have_ref_q <= 1'b1;
            end
         end
      end else begin : g_no_trans
         assign trans_ok = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/capbuf_seq.sv
module capbuf_seq
   import capbuf_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int TS_W  = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm,
   input  logic            trig,
   input  logic            store,
   input  logic [AW-1:0]   pre_cnt,
   output cap_state_e      state,
   output logic            active,
   output logic            trig_hit,
   output logic [AW-1:0]   wr_ptr,
   output logic [AW-1:0]   trig_addr,
   output logic [CW-1:0]   fill,
   output logic [TS_W-1:0] ts,
   output logic            ts_ovf
);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [CW-1:0] rem;
   logic [CW-1:0] post_len;

   assign post_len = FULL - {1'b0, pre_cnt};
   assign active   = (state == CAP_RUN) || (state == CAP_POST);
   assign trig_hit = (state == CAP_RUN) && trig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= CAP_IDLE;
         wr_ptr    <= '0;
         trig_addr <= '0;
         fill      <= '0;
         ts        <= '0;
         ts_ovf    <= 1'b0;
         rem       <= '0;
      end else if (arm) begin
         state     <= CAP_RUN;
         wr_ptr    <= '0;
         trig_addr <= '0;
         fill      <= '0;
         ts        <= '0;
         ts_ovf    <= 1'b0;
         rem       <= '0;
      end else begin
         if (active) begin
            ts <= ts + 1'b1;
            if (&ts) ts_ovf <= 1'b1;
         end
         if (store) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (fill != FULL) fill <= fill + 1'b1;
         end
         if (trig_hit) begin
            trig_addr <= wr_ptr;
            if (post_len == CW'(1)) begin
               state <= CAP_DONE;
            end else begin
               state <= CAP_POST;
               rem   <= post_len - 1'b1;
            end
         end else if ((state == CAP_POST) && store) begin
            rem <= rem - 1'b1;
            if (rem == CW'(1)) state <= CAP_DONE;
         end
      end
   end
endmodule

// File: rtl/capbuf_mem.sv
module capbuf_mem #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int TS_W   = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [TS_W-1:0]   wts,
   input  logic [AW-1:0]     oldest,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [TS_W-1:0]   rd_ts
);
   logic [DATA_W-1:0] dat_mem [DEPTH];
   logic [TS_W-1:0]   ts_mem  [DEPTH];
   logic [AW-1:0]     phys;

   always_ff @(posedge clk) begin
      if (we) begin
         dat_mem[waddr] <= wdata;
         ts_mem[waddr]  <= wts;
      end
   end

   assign phys    = oldest + rd_addr;
   assign rd_data = dat_mem[phys];
   assign rd_ts   = ts_mem[phys];
endmodule

// File: rtl/capbuf_ctrl.sv
module capbuf_ctrl
   import capbuf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 16,
   parameter int TS_W      = 16,
   parameter bit HAS_TRANS = 1'b1,
   localparam int AW       = $clog2(DEPTH),
   localparam int CW       = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              trig,
   input  logic [DATA_W-1:0] din,
   input  logic              qual,
   input  logic              mode_trans,
   input  logic              mode_qual,
   input  logic [AW-1:0]     pre_cnt,
   input  logic [AW-1:0]     rd_addr,
   output logic              busy,
   output logic              done,
   output logic [AW-1:0]     trig_addr,
   output logic [CW-1:0]     valid_cnt,
   output logic              ts_ovf,
   output logic [DATA_W-1:0] rd_data,
   output logic [TS_W-1:0]   rd_ts
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("capbuf_ctrl: DEPTH must be a power of two, at least 2");
      end
      if (TS_W < CW) begin : g_bad_ts
         $error("capbuf_ctrl: TS_W must cover at least one full buffer");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("capbuf_ctrl: DATA_W must be positive");
      end
   endgenerate

   cap_state_e      state;
   logic            active;
   logic            trig_hit;
   logic            store;
   logic [AW-1:0]   wr_ptr;
   logic [CW-1:0]   fill;
   logic [TS_W-1:0] ts;
   logic [AW-1:0]   oldest;

   capbuf_seq #(.DEPTH(DEPTH), .TS_W(TS_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (arm),
      .trig      (trig),
      .store     (store),
      .pre_cnt   (pre_cnt),
      .state     (state),
      .active    (active),
      .trig_hit  (trig_hit),
      .wr_ptr    (wr_ptr),
      .trig_addr (trig_addr),
      .fill      (fill),
      .ts        (ts),
      .ts_ovf    (ts_ovf)
   );

   capbuf_filter #(.DATA_W(DATA_W), .HAS_TRANS(HAS_TRANS)) u_filter (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm         (arm),
      .active      (active),
      .force_store (trig_hit),
      .din         (din),
      .qual        (qual),
      .mode_trans  (mode_trans),
      .mode_qual   (mode_qual),
      .store       (store)
   );

   assign oldest = (fill == CW'(DEPTH)) ? wr_ptr : '0;

   capbuf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TS_W(TS_W)) u_mem (
      .clk     (clk),
      .we      (store),
      .waddr   (wr_ptr),
      .wdata   (din),
      .wts     (ts),
      .oldest  (oldest),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .rd_ts   (rd_ts)
   );

   assign busy      = active;
   assign done      = (state == CAP_DONE);
   assign valid_cnt = fill;
endmodule

// File: rtl/capbuf_chk.sv
module capbuf_chk #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          arm,
   input logic          trig,
   input logic          qual,
   input logic          mode_qual,
   input logic          busy,
   input logic          done,
   input logic [AW-1:0] trig_addr,
   input logic [CW-1:0] valid_cnt,
   input logic          ts_ovf
);
   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done)); // R5
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      done && !arm |=> done && $stable(valid_cnt)); // R5
   AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> busy && !done && valid_cnt == '0 && !ts_ovf); // R2
   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      valid_cnt <= CW'(DEPTH)); // R7
   AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !arm |=> valid_cnt >= $past(valid_cnt)); // R3
   AST_TRIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      done && !arm |=> $stable(trig_addr)); // R4
   AST_QUAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_qual && !qual && !trig && !arm |=> $stable(valid_cnt)); // R10
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ts_ovf && !arm |=> ts_ovf); // R12
endmodule

bind capbuf_ctrl capbuf_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .arm       (arm),
   .trig      (trig),
   .qual      (qual),
   .mode_qual (mode_qual),
   .busy      (busy),
   .done      (done),
   .trig_addr (trig_addr),
   .valid_cnt (valid_cnt),
   .ts_ovf    (ts_ovf)
);

// File: tb/capbuf_ctrl_bench.sv
`timescale 1ns/1ps
module capbuf_ctrl_bench;
   localparam int DW = 8;
   localparam int D  = 8;
   localparam int TW = 8;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm = 1'b0, trig = 1'b0, qual = 1'b0;
   logic          mode_trans = 1'b0, mode_qual = 1'b0;
   logic [DW-1:0] din = '0;
   logic [AW-1:0] pre_cnt = '0, rd_addr = '0;
   logic          busy, done, ts_ovf;
   logic [AW-1:0] trig_addr;
   logic [AW:0]   valid_cnt;
   logic [DW-1:0] rd_data;
   logic [TW-1:0] rd_ts;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   capbuf_ctrl #(.DATA_W(DW), .DEPTH(D), .TS_W(TW)) u_capbuf_ctrl (
      .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .din(din), .qual(qual),
      .mode_trans(mode_trans), .mode_qual(mode_qual), .pre_cnt(pre_cnt),
      .rd_addr(rd_addr), .busy(busy), .done(done), .trig_addr(trig_addr),
      .valid_cnt(valid_cnt), .ts_ovf(ts_ovf), .rd_data(rd_data), .rd_ts(rd_ts)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int k, input int seed);
      if (seed == 0) return DW'(k);
      return DW'((k / ((seed % 4) + 1)) * 37 + seed);
   endfunction

   // One capture: arm, drive ncyc sample slots, then compare with a per-cycle
   // model built from the requirements.
   task automatic capture(input int pre, input bit mt, input bit mq, input int tk,
                          input int tk2, input int ncyc, input int seed, input string tag);
      logic [DW-1:0] ed [D];
      logic [TW-1:0] ets [D];
      logic [DW-1:0] last = '0;
      bit have = 0, trigd = 0, fin = 0;
      int cnt = 0, post_left = 0, trig_idx = 0, act_n = 0, valid, first;
      @(negedge clk);
      arm = 1'b1; pre_cnt = AW'(pre); mode_trans = mt; mode_qual = mq; trig = 1'b0;
      @(negedge clk);
      arm = 1'b0;
      for (int k = 0; k < ncyc; k++) begin
         logic [DW-1:0] d;
         bit q, t, st;
         d = pat(k, seed);
         q = ((k + seed) % 3) != 1;
         din = d; qual = q; trig = (k == tk) || (k == tk2);
         if (!fin) begin
            act_n++;
            t  = trig && !trigd;
            st = t || ((!mq || q) && (!mt || !have || d != last));
            if (st) begin
               ed[cnt % D] = d; ets[cnt % D] = TW'(k);
               cnt++; last = d; have = 1;
            end
            if (t) begin
               trigd = 1; trig_idx = cnt - 1; post_left = D - pre;
            end
            if (trigd && st) begin
               post_left--;
               if (post_left == 0) fin = 1;
            end
         end
         @(negedge clk);
      end
      trig = 1'b0; mode_qual = 1'b1; qual = 1'b0;
      valid = (cnt < D) ? cnt : D;
      first = cnt - valid;
      chk(done == fin, {tag, " R5 done"}, int'(done), int'(fin));
      chk(busy == !fin, {tag, " R5 busy"}, int'(busy), int'(!fin));
      chk(int'(valid_cnt) == valid, {tag, " R7 valid_cnt"}, int'(valid_cnt), valid);
      chk(ts_ovf == (act_n > 256), {tag, " R12 ts_ovf"}, int'(ts_ovf), int'(act_n > 256));
      if (trigd)
         chk(int'(trig_addr) == trig_idx % D, {tag, " R4 trig_addr"},
             int'(trig_addr), trig_idx % D);
      for (int i = 0; i < valid; i++) begin
         rd_addr = AW'(i);
         #1;
         chk(rd_data == ed[(first + i) % D], {tag, " R3 R8 rd_data"},
             int'(rd_data), int'(ed[(first + i) % D]));
         chk(rd_ts == ets[(first + i) % D], {tag, " R11 rd_ts"},
             int'(rd_ts), int'(ets[(first + i) % D]));
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !ts_ovf && valid_cnt == '0, "R1 reset outputs",
          int'({busy, done, ts_ovf}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && valid_cnt == '0, "R1 idle after reset", int'(busy), 0);
      // R6: late trigger, every pre-trigger count, second trigger during post phase
      for (int p = 0; p < D; p++) capture(p, 0, 0, 12, 14, 40, 0, "R6 late");
      // R7: early trigger, pre region not filled
      for (int p = 0; p < D; p++) capture(p, 0, 0, 2, -1, 40, 0, "R7 early");
      // R9 / R10: filters, alone and combined
      capture(3, 1, 0, 14, -1, 60, 5, "R9 trans");
      capture(5, 1, 0, 6, -1, 60, 7, "R9 trans");
      capture(3, 0, 1, 14, -1, 60, 6, "R10 qual");
      capture(0, 0, 1, 4, -1, 60, 9, "R10 qual");
      capture(4, 1, 1, 20, -1, 80, 6, "R9 R10 both");
      // R4: trigger after done ignored
      capture(6, 0, 0, 9, 30, 40, 3, "R4 late trig ignored");
      // R12: no trigger, timestamp wraps
      capture(4, 0, 0, -1, -1, 300, 2, "R12 wrap");
      // R2: re-arm while busy clears overflow and fill
      capture(2, 0, 0, 10, -1, 40, 4, "R2 R12 rearm");
      summary();
   end
endmodule